// File: doc/BRIEF.md
# Programmable Interval Down-Counter

A single 16-bit down-counting timer channel. It is programmed through a small byte-wide write port and produces one of three output waveforms on `out`. The three waveforms are a one-shot level that rises when the count expires, a periodic one-clock low strobe, and a near-symmetric square wave. The count decrements on each rising edge of `clk` while the `gate` input allows it. Counting can use plain binary or four packed decimal digits, and the choice is made when the channel is configured.

Software first writes a configuration byte, which selects the waveform and the number system. It then writes the count as two bytes, less significant first. A latch command captures the count at one instant so that its two bytes can be read back consistently while the counter keeps running. Without a latch, reads return the live count, one byte per read.

Top module: `pit_channel`

## Requirements
- R1: During and immediately after synchronous reset, `out` is 1, `rd_data` is 0 and the counter is stopped.
- R2: A write with `wr_addr`=1 and `wr_data[7]`=0 is a configuration byte. In it, `wr_data[2:1]` selects the waveform (00 one-shot, 01 strobe, 1x square) and `wr_data[0]`=1 selects decimal counting. From the next clock, counting stops and `out` is driven to 0 for one-shot or to 1 for the other waveforms. Both byte pointers are cleared and any held snapshot is dropped.
- R3: Two writes with `wr_addr`=0 supply the count, low byte first. The counter takes the new value on the clock after the high byte is written, and on that same clock `out` becomes 0 for one-shot and 1 otherwise.
- R4: One-shot: `out` stays 0 for N gate-enabled clocks after the load. It rises on the clock where the count reaches zero and stays 1 until the next load. While `gate` is 0, counting pauses.
- R5: Strobe: `out` is 0 for exactly one clock, while the count equals 1. On the following clock the count reloads, so the period is N clocks.
- R6: Square: `out` is 1 for ceil(N/2) clocks and 0 for floor(N/2) clocks, repeating. The count runs from N down to 1 and then reloads.
- R7: Strobe and square: while `gate` is 0, `out` is 1 and the count holds. The first clock with `gate` at 1 after it was 0 reloads the count and starts a new high phase.
- R8: A count of 0 means 65536 clocks in binary and 10000 clocks in decimal.
- R9: Decimal counting keeps each nibble in 0..9. A nibble at 0 borrows and becomes 9, so 0x0100 is followed by 0x0099.
- R10: A configuration-address write with `wr_data[7]`=1 captures the count present before that clock. The next two reads return the capture, low byte then high byte, while counting continues. A second latch command issued before both bytes are read is ignored.
- R11: With no capture held, reads return the live count, low byte then high byte, alternating.
- R12: `rd_data` is registered. It takes the selected byte on the clock where `rd_en` is 1 and holds its value on every other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = count byte, 1 = configuration or latch byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| gate | input | 1 | Count enable / restart trigger |
| out | output | 1 | Waveform output |

## Verification
The hardest situation to reach is a snapshot read that must differ from the live count. The stimulus holds `gate` low so the count sits at a known decimal value. It then releases `gate` for exactly one clock to force the 0x0100 to 0x0099 borrow, issues the latch, lets counting run, and issues a second latch that must have no effect. The maximum-count case needs a full 65536-clock one-shot, and the stimulus reaches it by first letting a short count expire so the falling edge of `out` marks the load.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RATE    = 2'd1,
    MODE_SQUARE  = 2'd2
  } pit_mode_e;
endpackage

// File: rtl/pit_decr.sv
module pit_decr #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] nxt
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0]      dec_nxt;
  logic [DIGITS-1:0] brw;

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    assign d = val[4*i +: 4];
    assign dec_nxt[4*i +: 4] = !brw[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (i < DIGITS - 1) begin : g_brw
      assign brw[i+1] = brw[i] && (d == 4'd0);
    end
  end

  assign nxt = bcd ? dec_nxt : (val - W'(1));
endmodule

// File: rtl/pit_half.sv
module pit_half #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic                bcd,
  output logic [4*DIGITS-1:0] half
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] dec_half;
  logic [W-1:0] bin_half;
  logic [W-1:0] dec_max_half;
  logic [W-1:0] bin_max_half;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    logic       up_odd;
    assign d = val[4*i +: 4];
    if (i == DIGITS - 1) begin : g_top
      assign up_odd = 1'b0;
    end else begin : g_mid
      assign up_odd = val[4*(i+1)];
    end
    assign dec_half[4*i +: 4] = {1'b0, d[3:1]} + (up_odd ? 4'd5 : 4'd0);
  end

  assign bin_half     = {1'b0, val[W-1:1]};
  assign dec_max_half = {4'd5, {(W-4){1'b0}}};
  assign bin_max_half = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (val == '0) half = bcd ? dec_max_half : bin_max_half;
    else           half = bcd ? dec_half : bin_half;
  end
endmodule

// File: rtl/pit_regif.sv
module pit_regif
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [CNT_W-1:0] cnt,
  output pit_mode_e        mode,
  output logic             bcd,
  output logic [CNT_W-1:0] reload,
  output logic             cfg_p,
  output logic             load_p,
  output logic [BUS_W-1:0] rd_data
);
  localparam int BYTES = CNT_W / BUS_W;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

  logic [CNT_W-1:0] staging, staged_next, snap, rd_src;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             latched;
  logic             is_ctrl, is_count;

  assign is_ctrl  = wr_en && wr_addr;
  assign is_count = wr_en && !wr_addr;
  assign rd_src   = latched ? snap : cnt;

  always_comb begin
    staged_next = staging;
    staged_next[int'(wr_idx)*BUS_W +: BUS_W] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_ONESHOT;
      bcd     <= 1'b0;
      reload  <= '0;
      staging <= '0;
      snap    <= '0;
      wr_idx  <= '0;
      rd_idx  <= '0;
      latched <= 1'b0;
      cfg_p   <= 1'b0;
      load_p  <= 1'b0;
      rd_data <= '0;
    end else begin
      cfg_p  <= 1'b0;
      load_p <= 1'b0;
      if (rd_en) begin
        rd_data <= rd_src[int'(rd_idx)*BUS_W +: BUS_W];
        if (rd_idx == LAST) begin
          rd_idx  <= '0;
          latched <= 1'b0;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
      if (is_ctrl) begin
        if (wr_data[BUS_W-1]) begin
          if (!latched) begin
            latched <= 1'b1;
            snap    <= cnt;
            rd_idx  <= '0;
          end
        end else begin
          mode    <= wr_data[2] ? MODE_SQUARE : (wr_data[1] ? MODE_RATE : MODE_ONESHOT);
          bcd     <= wr_data[0];
          cfg_p   <= 1'b1;
          wr_idx  <= '0;
          rd_idx  <= '0;
          latched <= 1'b0;
        end
      end else if (is_count) begin
        staging <= staged_next;
        if (wr_idx == LAST) begin
          wr_idx <= '0;
          reload <= staged_next;
          load_p <= 1'b1;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  pit_mode_e        mode,
  input  logic             bcd,
  input  logic [CNT_W-1:0] reload,
  input  logic             cfg_p,
  input  logic             load_p,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             out
);
  localparam int DIGITS = CNT_W / 4;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] nxt, half, low_at;
  logic             gate_q;

  pit_decr #(.DIGITS(DIGITS)) u_dec (.val(cnt), .bcd(bcd), .nxt(nxt));
  pit_half #(.DIGITS(DIGITS)) u_half (.val(reload), .bcd(bcd), .half(half));

  assign low_at = (mode == MODE_RATE) ? ONE : half;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      out    <= 1'b1;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cfg_p) begin
        run <= 1'b0;
        out <= (mode != MODE_ONESHOT);
      end else if (load_p) begin
        cnt <= reload;
        run <= 1'b1;
        out <= (mode != MODE_ONESHOT);
      end else if (run) begin
        if (mode == MODE_ONESHOT) begin
          if (gate) begin
            cnt <= nxt;
            if (nxt == '0) out <= 1'b1;
          end
        end else if (!gate) begin
          out <= 1'b1;
        end else if (!gate_q || cnt == ONE) begin
          cnt <= reload;
          out <= 1'b1;
        end else begin
          cnt <= nxt;
          if (nxt == low_at) out <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [BUS_W-1:0] rd_data,
  input  logic             gate,
  output logic             out
);
  pit_mode_e        mode;
  logic             bcd, cfg_p, load_p, run;
  logic [CNT_W-1:0] reload, cnt;

  pit_regif #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .cnt(cnt), .mode(mode), .bcd(bcd), .reload(reload),
    .cfg_p(cfg_p), .load_p(load_p), .rd_data(rd_data)
  );

  pit_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .gate(gate), .mode(mode), .bcd(bcd), .reload(reload),
    .cfg_p(cfg_p), .load_p(load_p), .cnt(cnt), .run(run), .out(out)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             gate,
  input logic             rd_en,
  input logic             out,
  input logic [BUS_W-1:0] rd_data,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input pit_mode_e        mode,
  input logic             cfg_p,
  input logic             load_p
);
  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> (out && rd_data == '0 && !run));

  assert_cfg_stop_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_p |=> !run);

  assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (run && mode == MODE_ONESHOT && out && !cfg_p && !load_p) |=> out);

  assert_rate_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (run && mode == MODE_RATE && gate && !out && !cfg_p && !load_p) |=> out);

  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (run && mode != MODE_ONESHOT && !gate && !cfg_p && !load_p) |=> (out && $stable(cnt)));

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .gate(gate), .rd_en(rd_en), .out(out), .rd_data(rd_data),
  .cnt(cnt), .run(run), .mode(mode), .cfg_p(cfg_p), .load_p(load_p)
);

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, gate = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       out;

  int nchk = 0, nbad = 0, cyc = 0;
  bit done = 1'b0, live = 1'b0;

  always #2 clk = ~clk;

  pit_channel u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                  .rd_en(rd_en), .rd_data(rd_data), .gate(gate), .out(out));

  // ---------------- reference model (integer arithmetic) ----------------
  int m_mode, m_bcd, m_raw, m_stage, m_cnt, m_out, m_run, m_gq, m_cfg, m_load;
  int m_widx, m_ridx, m_lat, m_snap, m_rd;
  int oc, mx, nv, nx, lowat, src;

  function automatic int to_bcd(int v);
    return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
  endfunction
  function automatic int enc(int v, int b);
    return b ? to_bcd(v) : v;
  endfunction
  function automatic int raw_val(int r, int b);
    if (!b) return r;
    return ((r >> 12) & 15) * 1000 + ((r >> 8) & 15) * 100 + ((r >> 4) & 15) * 10 + (r & 15);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_bcd = 0; m_raw = 0; m_stage = 0; m_cnt = 0; m_out = 1; m_run = 0;
      m_gq = 0; m_cfg = 0; m_load = 0; m_widx = 0; m_ridx = 0; m_lat = 0; m_snap = 0; m_rd = 0;
    end else begin
      oc = m_cnt;
      mx = m_bcd ? 10000 : 65536;
      nv = raw_val(m_raw, m_bcd);
      lowat = (m_mode == 1) ? 1 : (((nv == 0) ? mx : nv) / 2);
      if (m_cfg) begin
        m_run = 0; m_out = (m_mode == 0) ? 0 : 1;
      end else if (m_load) begin
        m_cnt = nv; m_run = 1; m_out = (m_mode == 0) ? 0 : 1;
      end else if (m_run) begin
        nx = (m_cnt == 0) ? mx - 1 : m_cnt - 1;
        if (m_mode == 0) begin
          if (gate) begin m_cnt = nx; if (nx == 0) m_out = 1; end
        end else if (!gate) m_out = 1;
        else if (!m_gq || m_cnt == 1) begin m_cnt = nv; m_out = 1; end
        else begin m_cnt = nx; if (nx == lowat) m_out = 0; end
      end
      m_gq = gate;
      m_cfg = 0; m_load = 0;
      if (rd_en) begin
        src = m_lat ? m_snap : enc(oc, m_bcd);
        m_rd = (m_ridx == 0) ? (src & 255) : ((src >> 8) & 255);
        if (m_ridx == 1) begin m_ridx = 0; m_lat = 0; end else m_ridx = 1;
      end
      if (wr_en && wr_addr) begin
        if (wr_data[7]) begin
          if (!m_lat) begin m_lat = 1; m_snap = enc(oc, m_bcd); m_ridx = 0; end
        end else begin
          m_mode = wr_data[2] ? 2 : (wr_data[1] ? 1 : 0);
          m_bcd = wr_data[0]; m_cfg = 1; m_widx = 0; m_ridx = 0; m_lat = 0;
        end
      end else if (wr_en) begin
        if (m_widx == 0) begin m_stage = wr_data; m_widx = 1; end
        else begin m_raw = m_stage | (int'(wr_data) << 8); m_widx = 0; m_load = 1; end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk(out == m_out[0], "R2/R3/R4/R5/R6/R7/R8 out vs model", out, m_out);
      chk(rd_data == m_rd[7:0], "R9/R10/R11/R12 rd_data vs model", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      nchk++; nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic wr(bit a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d[7:0];
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic load(int v);
    wr(1'b0, v & 255); wr(1'b0, (v >> 8) & 255);
  endtask
  task automatic rd(output int v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask
  task automatic low_width(output int n);
    n = 0;
    @(negedge clk);
    while (!out) begin n++; @(negedge clk); end
  endtask
  task automatic measure(output int hi, output int lo);
    while (out) @(negedge clk);
    while (!out) @(negedge clk);
    hi = 0; while (out) begin hi++; @(negedge clk); end
    lo = 0; while (!out) begin lo++; @(negedge clk); end
  endtask

  int n, hi, lo, b0, b1, c0, c1;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    @(negedge clk);
    chk(out == 1'b1, "R1 out after reset", out, 1);
    chk(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);

    // R2 / R3 / R4: one-shot binary
    wr(1'b1, 8'h00);
    @(negedge clk);
    chk(out == 1'b0, "R2 one-shot config drives out low", out, 0);
    load(5);
    repeat (10) @(negedge clk);
    load(5);
    chk(out == 1'b1, "R3 load waits one clock", out, 1);
    low_width(n);
    chk(n == 5, "R4 one-shot low width", n, 5);
    repeat (20) @(negedge clk);
    chk(out == 1'b1, "R4 stays high after terminal count", out, 1);

    // R4: gate pauses one-shot
    load(4);
    gate = 1'b0;
    repeat (5) @(negedge clk);
    gate = 1'b1;
    low_width(n);
    chk(n == 3, "R4 gate pause extends low phase", n, 3);

    // R5: strobe N=4
    wr(1'b1, 8'h02);
    load(4);
    measure(hi, lo);
    chk(lo == 1, "R5 strobe low width", lo, 1);
    chk(hi + lo == 4, "R5 strobe period", hi + lo, 4);

    // R6: square odd then even
    wr(1'b1, 8'h04);
    load(5);
    measure(hi, lo);
    chk(hi == 3, "R6 square odd high", hi, 3);
    chk(lo == 2, "R6 square odd low", lo, 2);
    load(6);
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R6 square even phases", hi * 10 + lo, 33);

    // R7: gate low forces high and holds count
    gate = 1'b0;
    repeat (2) @(negedge clk);
    chk(out == 1'b1, "R7 gate low forces out high", out, 1);
    rd(b0); rd(b1);
    repeat (3) @(negedge clk);
    rd(c0); rd(c1);
    chk(b0 == c0 && b1 == c1, "R7 count held while gate low", c1 * 256 + c0, b1 * 256 + b0);
    chk(out == 1'b1, "R7 still high", out, 1);
    gate = 1'b1;
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R7 waveform resumes after gate rise", hi * 10 + lo, 33);

    // R2: configuration stops counting
    wr(1'b1, 8'h00);
    rd(b0); rd(b1);
    repeat (20) @(negedge clk);
    rd(c0); rd(c1);
    chk(out == 1'b0, "R2 out low after one-shot config", out, 0);
    chk(b0 == c0 && b1 == c1, "R2 counting stopped", c1 * 256 + c0, b1 * 256 + b0);

    // R8: binary zero = 65536
    load(1);
    repeat (4) @(negedge clk);
    load(0);
    low_width(n);
    chk(n == 65536, "R8 binary zero count", n, 65536);

    // R8: decimal zero = 10000
    wr(1'b1, 8'h01);
    load(1);
    repeat (4) @(negedge clk);
    load(0);
    low_width(n);
    chk(n == 10000, "R8 decimal zero count", n, 10000);

    // R9 / R11: decimal borrow, live read
    gate = 1'b0;
    load(16'h0100);
    repeat (3) @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    gate = 1'b0;
    rd(b0); rd(b1);
    chk(b0 == 8'h99, "R9 R11 live low byte after borrow", b0, 8'h99);
    chk(b1 == 8'h00, "R9 R11 live high byte after borrow", b1, 0);

    // R10: latch snapshot, second latch ignored
    wr(1'b1, 8'h80);
    gate = 1'b1;
    repeat (7) @(negedge clk);
    wr(1'b1, 8'h80);
    repeat (3) @(negedge clk);
    rd(b0); rd(b1);
    chk(b0 == 8'h99, "R10 snapshot low byte", b0, 8'h99);
    chk(b1 == 8'h00, "R10 snapshot high byte", b1, 0);
    rd(c0); rd(c1);
    chk(c0 != 8'h99, "R10 live read after snapshot differs", c0, 8'h99);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule